// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides, for each request arriving from the upstream port, whether the bridge passes it to the downstream bus. Each request carries an address and a flag that marks it as an I/O or a memory access. The request is compared against four address ranges:

- an I/O window with 4 KB granularity;
- a 32-bit non-prefetchable memory window with 1 MB granularity;
- a 64-bit prefetchable memory window with 1 MB granularity;
- the fixed legacy display ranges, which an enable bit controls.

Window bounds are loaded through a single-cycle register write port. One clock after a request, the block presents a registered verdict and a code naming the range that claimed the access. Surrounding logic uses the verdict to steer the request to the downstream side or to handle it as unclaimed.

Top module: `fwd_window_decoder`

## Requirements
- R1: After reset the outputs read `fwd_valid_o=0`, `fwd_hit_o=0` and `fwd_win_o=0`. All three windows come out of reset disabled, and the legacy enable comes out of reset clear, so no access is claimed until software programs the registers.
- R2: `fwd_valid_o` follows `req_valid_i` one clock later. `fwd_hit_o` and `fwd_win_o` give the verdict for that request in the same cycle. When `fwd_valid_o` is 0, both `fwd_hit_o` and `fwd_win_o` read 0.
- R3: I/O window, written at select 0 and select 1.
  - Select 0 holds the base nibble in bits [7:4] and the limit nibble in bits [15:12].
  - Select 1 holds the upper base in bits [15:0] and the upper limit in bits [31:16].
  - The base is {upper base, base nibble, 12'h000} and the limit is {upper limit, limit nibble, 12'hFFF}.
  - An I/O request hits when base ≤ `req_addr_i[31:0]` ≤ limit, and the result is code 1.
- R4: Non-prefetchable memory window, written at select 2. Bits [15:4] give base address bits [31:20] and bits [31:20] give limit address bits [31:20]. The low 20 bits of the limit count as all ones. A memory request hits only when `req_addr_i[63:32]` is zero, and the result is code 2.
- R5: Prefetchable memory window.
  - Select 3 holds the low fields in the same layout as select 2.
  - Select 4 holds base address bits [63:32].
  - Select 5 holds limit address bits [63:32].
  - A memory request in the full 64-bit range gives code 3.
- R6: A window whose base is above its limit never matches.
- R7: I/O requests are never claimed by either memory window. Memory requests are never claimed by the I/O window.
- R8: Select 6 bit 0 enables the legacy display ranges. These are memory 0xA0000–0xBFFFF with the upper 32 address bits zero, and I/O ports 0x3B0–0x3BB and 0x3C0–0x3DF. A match gives code 4. While the bit is clear, these addresses are claimed only through the windows.
- R9: When ranges overlap, the legacy display range wins over the non-prefetchable window, which wins over the prefetchable window.
- R10: A register write and a request in the same cycle: the request is decoded with the register values from before the write. The next request sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select (0–6) |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Request present |
| req_is_io_i | input | 1 | 1 = I/O access, 0 = memory access |
| req_addr_i | input | 64 | Request address |
| fwd_valid_o | output | 1 | Verdict present (request delayed by one clock) |
| fwd_hit_o | output | 1 | Forward downstream |
| fwd_win_o | output | 3 | Claiming range: 0 none, 1 I/O, 2 memory, 3 prefetchable, 4 legacy display |

## Verification
A register write and a decode can land on the same clock edge. The bench provokes this by presenting a legacy display memory request in the same cycle that clears the enable bit. It expects code 4 for that request, and it expects code 0 for an identical request one cycle later. Overlap priority is judged by stacking the memory window on top of the legacy range and the prefetchable window on top of the memory window, then toggling the enable.

// File: rtl/fwd_window_pkg.sv
package fwd_window_pkg;
  localparam int ADDR_W   = 64;
  localparam int DATA_W   = 32;
  localparam int IO_SH    = 12;
  localparam int MEM_SH   = 20;
  localparam int IO_W     = 32 - IO_SH;
  localparam int MEM_W    = 32 - MEM_SH;
  localparam int PF_W     = ADDR_W - MEM_SH;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_IO   = 3'd1,
    WIN_MEM  = 3'd2,
    WIN_PREF = 3'd3,
    WIN_VGA  = 3'd4
  } win_e;

  localparam logic [2:0] SEL_IO_LO   = 3'd0;
  localparam logic [2:0] SEL_IO_HI   = 3'd1;
  localparam logic [2:0] SEL_MEM     = 3'd2;
  localparam logic [2:0] SEL_PF_LO   = 3'd3;
  localparam logic [2:0] SEL_PF_BHI  = 3'd4;
  localparam logic [2:0] SEL_PF_LHI  = 3'd5;
  localparam logic [2:0] SEL_CTRL    = 3'd6;
endpackage

// File: rtl/win_regs.sv
module win_regs
  import fwd_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IO_W-1:0]   io_base_o,
  output logic [IO_W-1:0]   io_lim_o,
  output logic [MEM_W-1:0]  mem_base_o,
  output logic [MEM_W-1:0]  mem_lim_o,
  output logic [PF_W-1:0]   pf_base_o,
  output logic [PF_W-1:0]   pf_lim_o,
  output logic              vga_en_o
);
  logic [DATA_W-1:0] io_lo_q, io_hi_q, mem_q, pf_lo_q, pf_bhi_q, pf_lhi_q;
  logic              vga_q;

  // reset values leave every window with base above limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_lo_q  <= 32'h0000_00F0;
      io_hi_q  <= 32'h0000_FFFF;
      mem_q    <= 32'h0000_FFF0;
      pf_lo_q  <= 32'h0000_FFF0;
      pf_bhi_q <= '1;
      pf_lhi_q <= '0;
      vga_q    <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        SEL_IO_LO:  io_lo_q  <= wdata_i;
        SEL_IO_HI:  io_hi_q  <= wdata_i;
        SEL_MEM:    mem_q    <= wdata_i;
        SEL_PF_LO:  pf_lo_q  <= wdata_i;
        SEL_PF_BHI: pf_bhi_q <= wdata_i;
        SEL_PF_LHI: pf_lhi_q <= wdata_i;
        SEL_CTRL:   vga_q    <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign io_base_o  = {io_hi_q[15:0],  io_lo_q[7:4]};
  assign io_lim_o   = {io_hi_q[31:16], io_lo_q[15:12]};
  assign mem_base_o = mem_q[15:4];
  assign mem_lim_o  = mem_q[31:20];
  assign pf_base_o  = {pf_bhi_q[ADDR_W-33:0], pf_lo_q[15:4]};
  assign pf_lim_o   = {pf_lhi_q[ADDR_W-33:0], pf_lo_q[31:20]};
  assign vga_en_o   = vga_q;
endmodule

// File: rtl/range_match.sv
module range_match #(
  parameter int W = 12
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] lim_i,
  input  logic [W-1:0] addr_i,
  output logic         hit_o
);
  // compare only the aligned upper bits: limit low bits act as all ones
  assign hit_o = (base_i <= lim_i) && (addr_i >= base_i) && (addr_i <= lim_i);
endmodule

// File: rtl/vga_match.sv
module vga_match
  import fwd_window_pkg::*;
(
  input  logic              is_io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] MEM_LO  = 'h000A_0000;
  localparam logic [ADDR_W-1:0] MEM_HI  = 'h000B_FFFF;
  localparam logic [31:0]       IOA_LO  = 32'h3B0;
  localparam logic [31:0]       IOA_HI  = 32'h3BB;
  localparam logic [31:0]       IOB_LO  = 32'h3C0;
  localparam logic [31:0]       IOB_HI  = 32'h3DF;

  logic mem_hit, io_hit;
  assign mem_hit = (addr_i >= MEM_LO) && (addr_i <= MEM_HI);
  assign io_hit  = ((addr_i[31:0] >= IOA_LO) && (addr_i[31:0] <= IOA_HI)) ||
                   ((addr_i[31:0] >= IOB_LO) && (addr_i[31:0] <= IOB_HI));
  assign hit_o   = is_io_i ? io_hit : mem_hit;
endmodule

// File: rtl/fwd_window_decoder.sv
module fwd_window_decoder
  import fwd_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_is_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              fwd_valid_o,
  output logic              fwd_hit_o,
  output logic [2:0]        fwd_win_o
);
  logic [IO_W-1:0]  io_base, io_lim;
  logic [MEM_W-1:0] mem_base, mem_lim;
  logic [PF_W-1:0]  pf_base, pf_lim;
  logic             vga_en;
  logic             io_hit, mem_hit_raw, pf_hit, vga_hit;
  logic             mem_hit;
  win_e             win_d, win_q;
  logic             valid_q;

  win_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .io_base_o(io_base), .io_lim_o(io_lim),
    .mem_base_o(mem_base), .mem_lim_o(mem_lim),
    .pf_base_o(pf_base), .pf_lim_o(pf_lim),
    .vga_en_o(vga_en)
  );

  range_match #(.W(IO_W)) u_io (
    .base_i(io_base), .lim_i(io_lim), .addr_i(req_addr_i[31:IO_SH]), .hit_o(io_hit));
  range_match #(.W(MEM_W)) u_mem (
    .base_i(mem_base), .lim_i(mem_lim), .addr_i(req_addr_i[31:MEM_SH]), .hit_o(mem_hit_raw));
  range_match #(.W(PF_W)) u_pf (
    .base_i(pf_base), .lim_i(pf_lim), .addr_i(req_addr_i[ADDR_W-1:MEM_SH]), .hit_o(pf_hit));
  vga_match u_vga (.is_io_i(req_is_io_i), .addr_i(req_addr_i), .hit_o(vga_hit));

  assign mem_hit = mem_hit_raw && (req_addr_i[ADDR_W-1:32] == '0);

  always_comb begin
    win_d = WIN_NONE;
    if (req_valid_i) begin
      if (vga_en && vga_hit)      win_d = WIN_VGA;
      else if (req_is_io_i) begin
        if (io_hit)               win_d = WIN_IO;
      end else if (mem_hit)       win_d = WIN_MEM;
      else if (pf_hit)            win_d = WIN_PREF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      win_q   <= WIN_NONE;
    end else begin
      valid_q <= req_valid_i;
      win_q   <= win_d;
    end
  end

  assign fwd_valid_o = valid_q;
  assign fwd_win_o   = win_q;
  assign fwd_hit_o   = (win_q != WIN_NONE);

  // ---- assertions ----
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (fwd_valid_o == $past(req_valid_i)));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_valid_o |-> (!fwd_hit_o && fwd_win_o == 3'd0));
  p_io_no_mem_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(req_valid_i && req_is_io_i)) |-> (fwd_win_o != WIN_MEM && fwd_win_o != WIN_PREF));
  p_mem_no_io_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(req_valid_i && !req_is_io_i)) |-> (fwd_win_o != WIN_IO));
  p_vga_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fwd_win_o == WIN_VGA) |-> $past(vga_en));
  p_mem_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fwd_win_o == WIN_MEM) |-> $past(mem_base <= mem_lim));
  p_io_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fwd_win_o == WIN_IO) |-> $past(io_base <= io_lim));
endmodule

// File: tb/fwd_window_decoder_test.sv
module fwd_window_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_is_io_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        fwd_valid_o, fwd_hit_o;
  logic [2:0]  fwd_win_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fwd_window_decoder uut (.*);

  // {is_io, address, expected code}
  localparam int NV = 26;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 64'h0000_0000_0001_2000, 3'd1},
    {1'b1, 64'h0000_0000_0001_4FFF, 3'd1},
    {1'b1, 64'h0000_0000_0001_5000, 3'd0},
    {1'b1, 64'h0000_0000_0001_1FFF, 3'd0},
    {1'b0, 64'h0000_0000_0001_3000, 3'd0},
    {1'b0, 64'h0000_0000_E000_0000, 3'd2},
    {1'b0, 64'h0000_0000_E02F_FFFF, 3'd2},
    {1'b0, 64'h0000_0000_E030_0000, 3'd0},
    {1'b0, 64'h0000_0001_E000_0000, 3'd0},
    {1'b0, 64'h0000_0002_4000_0000, 3'd3},
    {1'b0, 64'h0000_0002_40FF_FFFF, 3'd3},
    {1'b0, 64'h0000_0002_4100_0000, 3'd0},
    {1'b0, 64'h0000_0000_4000_0000, 3'd0},
    {1'b1, 64'h0000_0002_4000_0000, 3'd0},
    {1'b0, 64'h0000_0000_000A_0000, 3'd4},
    {1'b0, 64'h0000_0000_000B_FFFF, 3'd4},
    {1'b0, 64'h0000_0000_000C_0000, 3'd0},
    {1'b0, 64'h0000_0000_0009_FFFF, 3'd0},
    {1'b1, 64'h0000_0000_0000_03B0, 3'd4},
    {1'b1, 64'h0000_0000_0000_03BB, 3'd4},
    {1'b1, 64'h0000_0000_0000_03BC, 3'd0},
    {1'b1, 64'h0000_0000_0000_03C0, 3'd4},
    {1'b1, 64'h0000_0000_0000_03DF, 3'd4},
    {1'b1, 64'h0000_0000_0000_03E0, 3'd0},
    {1'b1, 64'h0000_0000_000A_0000, 3'd0},
    {1'b0, 64'h0000_0000_0000_03C0, 3'd0}
  };

  task automatic check(input string req, input logic [2:0] exp_win, input logic exp_valid);
    logic exp_hit;
    exp_hit = (exp_win != 3'd0);
    n_chk++;
    if (fwd_valid_o !== exp_valid || fwd_hit_o !== exp_hit || fwd_win_o !== exp_win) begin
      n_bad++;
      $display("FAIL %s: valid/hit/win = %0b/%0b/%0d expected %0b/%0b/%0d",
               req, fwd_valid_o, fwd_hit_o, fwd_win_o, exp_valid, exp_hit, exp_win);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic req(input string tag, input logic io, input logic [63:0] a, input logic [2:0] exp);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_is_io_i = io; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(tag, exp, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    check("R1 reset", 3'd0, 1'b0);
    rst_ni = 1'b1;
    // R1: nothing claimed before programming
    req("R1 io unprogrammed", 1'b1, 64'h0, 3'd0);
    req("R1 mem unprogrammed", 1'b0, 64'h0, 3'd0);
    req("R1 vga off at reset", 1'b0, 64'hA_0000, 3'd0);

    // R3 R4 R5 R8 programming
    wr(3'd0, 32'h0000_4020);
    wr(3'd1, 32'h0001_0001);
    wr(3'd2, 32'hE020_E000);
    wr(3'd3, 32'h40F0_4000);
    wr(3'd4, 32'h0000_0002);
    wr(3'd5, 32'h0000_0002);
    wr(3'd6, 32'h0000_0001);

    for (int i = 0; i < NV; i++) begin
      req($sformatf("R3/R4/R5/R7/R8 vector %0d", i), VEC[i][67], VEC[i][66:3], VEC[i][2:0]);
    end

    // R2: idle cycle reads quiet
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2 idle", 3'd0, 1'b0);

    // R10: same-cycle write of enable off with a legacy request
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd6; cfg_wdata_i = 32'h0;
    req_valid_i = 1'b1; req_is_io_i = 1'b0; req_addr_i = 64'hA_0000;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    check("R10 old value used", 3'd4, 1'b1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R10 new value seen / R8 disabled", 3'd0, 1'b1);

    // R9: memory window covering legacy range, 0x00000-0x00FFFFF
    wr(3'd2, 32'h0000_0000);
    req("R9 mem claims when legacy off", 1'b0, 64'hA_0000, 3'd2);
    wr(3'd6, 32'h1);
    req("R9 legacy beats mem", 1'b0, 64'hA_0000, 3'd4);
    // prefetchable overlapping memory window
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
    req("R9 mem beats prefetchable", 1'b0, 64'h5_0000, 3'd2);

    // R6: base above limit disables
    wr(3'd2, 32'hE000_E010);
    req("R6 mem disabled", 1'b0, 64'hE000_0000, 3'd0);
    wr(3'd0, 32'h0000_1020);
    wr(3'd1, 32'h0001_0001);
    req("R6 io disabled", 1'b1, 64'h1_1000, 3'd0);
    // R5: upper limit below upper base disables though low fields ok
    wr(3'd3, 32'h40F0_4000);
    wr(3'd4, 32'h3);
    wr(3'd5, 32'h2);
    req("R6 prefetchable disabled", 1'b0, 64'h2_4000_0000, 3'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule